// File: doc/BRIEF.md
# Serial 8N1 Transceiver with Run-Time Rate Presets

This block is a full-duplex asynchronous serial link endpoint with one frame shape: a low start bit, eight data bits sent least significant bit first, no parity, and a single high stop bit. The line rests high between frames. A parallel byte and a start strobe launch a transmit frame, and a busy flag covers the whole frame. On the receive side, a synchronized falling edge opens a frame. The start bit is checked again half a bit later, each bit is sampled at its centre, and the result is reported as either a one-cycle completion pulse with the byte or a one-cycle framing-error pulse.

The bit period is derived from a 48 MHz system clock. A two-bit selector picks one of three presets: 1.2, 1.5 or 2 megabaud, which are 40, 32 or 24 clock cycles per bit. Both directions share the active divisor. A new selection is adopted only on a clock edge where neither direction has a frame in progress, so a frame always runs at a single rate from start to finish.

Top module: `uart_8n1_xcvr`

## Requirements
- R1: When not transmitting, tx_o is high. A frame is a low start bit, then data bits 0 through 7 in that order, then a high stop bit. Each bit lasts D clock cycles, where D is the active divisor.
- R2: If tx_start_i is high on an edge where tx_busy_o is low, that edge launches a frame carrying tx_data_i, and tx_o is low from the next cycle. While tx_busy_o is high, tx_start_i and tx_data_i have no effect on the frame in flight.
- R3: tx_busy_o is high for exactly 10*D cycles after the launching edge, then low for at least one cycle. A start held high sends back-to-back frames with one idle cycle between them.
- R4: The rate selector encodes 00 as D=40 (1.2 MBd), 01 as D=32 (1.5 MBd), 10 as D=24 (2 MBd) and 11 as D=32. After reset, D is 32.
- R5: The active divisor takes the selector's value only on an edge where the transmitter is not busy and the receiver is idle. A frame in progress keeps the divisor it started with.
- R6: rx_i passes through two synchronizing flops before edge detection. For a valid frame, rx_done_o is high in exactly one cycle, 3 + D/2 + 9*D cycles after the first clock edge that samples the low start bit. In that cycle rx_data_o holds the received byte, least significant bit first. rx_data_o is 0 after reset and otherwise changes only together with rx_done_o.
- R7: If the line is high again when sampled half a bit after the falling edge, the receiver returns to idle and raises neither rx_done_o nor rx_ferr_o.
- R8: If the sampled stop bit is low, rx_ferr_o pulses for one cycle at the time rx_done_o would have pulsed. rx_done_o stays low and rx_data_o keeps its previous value.
- R9: Transmit and receive run independently. A receive completion and a transmit launch may fall on the same edge without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 48 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_sel_i | input | 2 | Rate preset select |
| tx_data_i | input | 8 | Byte to transmit |
| tx_start_i | input | 1 | Launch request for a transmit frame |
| tx_o | output | 1 | Serial transmit line, idles high |
| tx_busy_o | output | 1 | High while a transmit frame is in progress |
| rx_i | input | 1 | Serial receive line, asynchronous |
| rx_data_o | output | 8 | Last byte received correctly |
| rx_done_o | output | 1 | One-cycle pulse when a valid frame completes |
| rx_ferr_o | output | 1 | One-cycle pulse on a low stop bit |

## Verification
Two events can land on the same clock edge: the receiver's stop-bit decision, which raises rx_done_o, and the transmitter's launch of a new frame. The bench provokes this by timing a tx_start_i pulse so that it is sampled on exactly the edge that finishes a received frame. A behavioural model then compares both outputs on every cycle. The model confirms that the completion pulse and byte are correct, that the new frame starts with its low start bit on the following cycle, and that the divisor stays unchanged across that edge, because the receiver was still busy just before it.

// File: rtl/uart8n1_pkg.sv
package uart8n1_pkg;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 2;

  typedef enum logic [1:0] {
    RATE_1M2 = 2'b00,
    RATE_1M5 = 2'b01,
    RATE_2M0 = 2'b10,
    RATE_RSV = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rate_ctl.sv
module uart_rate_ctl import uart8n1_pkg::*; #(
  parameter int unsigned DIV_1M2 = 40,
  parameter int unsigned DIV_1M5 = 32,
  parameter int unsigned DIV_2M0 = 24,
  parameter int unsigned CNT_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             tx_idle_i,
  input  logic             rx_idle_i,
  output logic [CNT_W-1:0] div_o
);
  logic [CNT_W-1:0] div_q, div_d;

  always_comb begin
    case (rate_e'(sel_i))
      RATE_1M2: div_d = CNT_W'(DIV_1M2);
      RATE_2M0: div_d = CNT_W'(DIV_2M0);
      default:  div_d = CNT_W'(DIV_1M5);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    div_q <= CNT_W'(DIV_1M5);
    else if (tx_idle_i && rx_idle_i) div_q <= div_d;
  end

  assign div_o = div_q;

  p_div_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == CNT_W'(DIV_1M2)) || (div_q == CNT_W'(DIV_1M5)) || (div_q == CNT_W'(DIV_2M0)));

  p_div_hold_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_idle_i && rx_idle_i) |=> $stable(div_q));
endmodule

// File: rtl/uart_tx_8n1.sv
module uart_tx_8n1 import uart8n1_pkg::*; #(
  parameter int unsigned CNT_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     div_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 start_i,
  output logic                 line_o,
  output logic                 busy_o
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic               busy_q, line_q;
  logic [DATA_BITS:0] rest_q;   // remaining data bits plus stop bit
  logic [CNT_W-1:0]   cnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic               bit_end, frame_end;

  assign bit_end   = (cnt_q == div_i - CNT_W'(1));
  assign frame_end = bit_end && (bit_q == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      rest_q <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        line_q <= 1'b0;
        rest_q <= {1'b1, data_i};
        cnt_q  <= '0;
        bit_q  <= '0;
      end
    end else if (bit_end) begin
      cnt_q <= '0;
      if (frame_end) begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end else begin
        bit_q  <= bit_q + BIT_W'(1);
        line_q <= rest_q[0];
        rest_q <= {1'b1, rest_q[DATA_BITS:1]};
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign line_o = line_q;
  assign busy_o = busy_q;

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> line_q);

  p_launch_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !line_q);

  p_stop_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_q == BIT_W'(FRAME_BITS - 1)) |-> line_q);

  p_busy_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !frame_end) |=> busy_q);
endmodule

// File: rtl/uart_rx_8n1.sv
module uart_rx_8n1 import uart8n1_pkg::*; #(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     div_i,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 done_o,
  output logic                 ferr_o,
  output logic                 idle_o
);
  localparam int unsigned BIT_W = $clog2(DATA_BITS);

  logic [SYNC_STAGES:0]   sync_q;   // top bit is the delayed copy for edge detect
  logic                   line, line_prev;
  rx_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BIT_W-1:0]       bit_q;
  logic [DATA_BITS-1:0]   sh_q, data_q;
  logic                   done_q, ferr_q;
  logic [CNT_W-1:0]       half_m1, full_m1;

  assign line      = sync_q[SYNC_STAGES-1];
  assign line_prev = sync_q[SYNC_STAGES];
  assign half_m1   = (div_i >> 1) - CNT_W'(1);
  assign full_m1   = div_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], rx_i};
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (line_prev && !line) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (cnt_q == half_m1) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= line ? RX_IDLE : RX_DATA;  // high again: glitch
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        RX_DATA: begin
          if (cnt_q == full_m1) begin
            cnt_q <= '0;
            sh_q  <= {line, sh_q[DATA_BITS-1:1]};
            if (bit_q == BIT_W'(DATA_BITS - 1)) state_q <= RX_STOP;
            else                                bit_q   <= bit_q + BIT_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == full_m1) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            if (line) begin
              data_q <= sh_q;
              done_q <= 1'b1;
            end else begin
              ferr_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;
  assign ferr_o = ferr_q;
  assign idle_o = (state_q == RX_IDLE);

  p_done_ferr_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && ferr_q));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_ferr_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_q |=> !ferr_q);

  p_data_only_on_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(data_q));

  p_glitch_to_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && cnt_q == half_m1 && line) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/uart_8n1_xcvr.sv
module uart_8n1_xcvr import uart8n1_pkg::*; #(
  parameter int unsigned DIV_1M2     = 40,
  parameter int unsigned DIV_1M5     = 32,
  parameter int unsigned DIV_2M0     = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           baud_sel_i,
  input  logic [DATA_BITS-1:0] tx_data_i,
  input  logic                 tx_start_i,
  output logic                 tx_o,
  output logic                 tx_busy_o,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_done_o,
  output logic                 rx_ferr_o
);
  localparam int unsigned DIV_A   = (DIV_1M2 > DIV_1M5) ? DIV_1M2 : DIV_1M5;
  localparam int unsigned DIV_MAX = (DIV_A > DIV_2M0) ? DIV_A : DIV_2M0;
  localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] div;
  logic             tx_busy, rx_idle;

  uart_rate_ctl #(
    .DIV_1M2 (DIV_1M2),
    .DIV_1M5 (DIV_1M5),
    .DIV_2M0 (DIV_2M0),
    .CNT_W   (CNT_W)
  ) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (baud_sel_i),
    .tx_idle_i (!tx_busy),
    .rx_idle_i (rx_idle),
    .div_o     (div)
  );

  uart_tx_8n1 #(.CNT_W(CNT_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div),
    .data_i  (tx_data_i),
    .start_i (tx_start_i),
    .line_o  (tx_o),
    .busy_o  (tx_busy)
  );

  uart_rx_8n1 #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div),
    .rx_i   (rx_i),
    .data_o (rx_data_o),
    .done_o (rx_done_o),
    .ferr_o (rx_ferr_o),
    .idle_o (rx_idle)
  );

  assign tx_busy_o = tx_busy;
endmodule

// File: tb/uart_8n1_xcvr_test.sv
module uart_8n1_xcvr_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] baud_sel_i = 2'b01;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_start_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       tx_o, tx_busy_o, rx_done_o, rx_ferr_o;
  logic [7:0] rx_data_o;

  uart_8n1_xcvr uut (
    .clk_i(clk), .rst_ni(rst_ni), .baud_sel_i(baud_sel_i),
    .tx_data_i(tx_data_i), .tx_start_i(tx_start_i), .tx_o(tx_o), .tx_busy_o(tx_busy_o),
    .rx_i(rx_i), .rx_data_o(rx_data_o), .rx_done_o(rx_done_o), .rx_ferr_o(rx_ferr_o)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit fin = 1'b0;

  // reference model state
  int         m_div = 32, m_cnt = 0;
  bit         m_busy = 1'b0, m_was;
  logic [9:0] m_frame = '1;
  bit         rx_pend = 1'b0, hit;
  int         rx_t0 = 0, rx_d = 32;
  logic [7:0] rx_b = 8'h00, m_data = 8'h00;
  logic       rx_stop = 1'b1, exp_tx;

  function automatic int dec(input logic [1:0] s);
    case (s)
      2'b00:   return 40;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d act=%0h exp=%0h", what, cyc, act, exp);
    end
  endtask

  // model advances on each edge (R3, R4, R5)
  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_div = 32; m_busy = 1'b0; m_cnt = 0;
    end else begin
      m_was = m_busy;
      if (!m_was && !rx_pend) m_div = dec(baud_sel_i);
      if (m_was) begin
        m_cnt++;
        if (m_cnt == 10 * m_div) m_busy = 1'b0;
      end else if (tx_start_i) begin
        m_busy = 1'b1; m_cnt = 0; m_frame = {1'b1, tx_data_i, 1'b0};
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_ni && !fin) begin
      exp_tx = m_busy ? m_frame[4'(m_cnt / m_div)] : 1'b1;
      check("R1 tx line", 8'(tx_o), 8'(exp_tx));
      check("R3 tx busy", 8'(tx_busy_o), 8'(m_busy));
      hit = rx_pend && (cyc == rx_t0 + 3 + rx_d / 2 + 9 * rx_d);
      if (hit && rx_stop) m_data = rx_b;
      check("R6 rx done", 8'(rx_done_o), 8'(hit && rx_stop));
      check("R8 rx ferr", 8'(rx_ferr_o), 8'(hit && !rx_stop));
      check("R6 rx data", rx_data_o, m_data);
      if (hit) rx_pend = 1'b0;
    end
  end

  task automatic tx_go(input logic [7:0] d);
    @(negedge clk); tx_data_i = d; tx_start_i = 1'b1;
    @(negedge clk); tx_start_i = 1'b0;
  endtask

  task automatic wait_tx_idle();
    while (tx_busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop);
    int d;
    @(negedge clk);
    d = m_div;
    rx_t0 = cyc; rx_d = d; rx_b = b; rx_stop = stop; rx_pend = 1'b1;
    rx_i = 1'b0;
    repeat (d) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx_i = b[k];
      repeat (d) @(negedge clk);
    end
    rx_i = stop;
    repeat (d) @(negedge clk);
    rx_i = 1'b1;
    repeat (d) @(negedge clk);
  endtask

  task automatic set_rate(input logic [1:0] s);
    @(negedge clk); baud_sel_i = s;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R1, R4, R6)
    check("R1 reset tx_o", 8'(tx_o), 8'h01);
    check("R3 reset busy", 8'(tx_busy_o), 8'h00);
    check("R6 reset done", 8'(rx_done_o), 8'h00);
    check("R8 reset ferr", 8'(rx_ferr_o), 8'h00);
    check("R6 reset data", rx_data_o, 8'h00);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R4: default rate, both directions
    tx_go(8'hA5); wait_tx_idle();
    rx_frame(8'h3C, 1'b1);

    // R4: slow preset, R9: rx completion and tx launch on one edge
    set_rate(2'b00);
    fork
      rx_frame(8'h80, 1'b1);
      begin
        @(negedge clk);
        repeat (3 + 20 + 9 * 40 - 2) @(negedge clk);
        tx_go(8'h01);
      end
    join
    wait_tx_idle();

    // R4: fast preset, R9 overlapped traffic
    set_rate(2'b10);
    fork
      begin tx_go(8'hFF); wait_tx_idle(); end
      rx_frame(8'h00, 1'b1);
    join

    // R4: reserved code maps to middle rate
    set_rate(2'b11);
    tx_go(8'h5A); wait_tx_idle();
    rx_frame(8'hC3, 1'b1);

    // R5: select change mid-frame has no effect until idle
    set_rate(2'b01);
    tx_go(8'h96);
    repeat (50) @(negedge clk);
    baud_sel_i = 2'b10;
    wait_tx_idle();
    tx_go(8'h4B); wait_tx_idle();

    // R2: start and data ignored while busy
    tx_go(8'h11);
    repeat (40) @(negedge clk);
    tx_data_i = 8'hEE; tx_start_i = 1'b1;
    repeat (5) @(negedge clk);
    tx_start_i = 1'b0;
    wait_tx_idle();

    // R3: start held high, back-to-back frames
    @(negedge clk); tx_data_i = 8'h69; tx_start_i = 1'b1;
    @(negedge clk);
    while (tx_busy_o) @(negedge clk);
    @(negedge clk);
    tx_start_i = 1'b0;
    wait_tx_idle();

    // R7: short low glitch
    @(negedge clk); rx_i = 1'b0;
    repeat (4) @(negedge clk);
    rx_i = 1'b1;
    repeat (80) @(negedge clk);
    rx_frame(8'h7E, 1'b1);

    // R8: low stop bit
    rx_frame(8'h99, 1'b0);
    repeat (20) @(negedge clk);
    rx_frame(8'h24, 1'b1);

    repeat (20) @(negedge clk);
    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule